// File: doc/BRIEF.md
# Block Write-Protect Status Register

This block keeps the status byte of a small serial memory. The byte holds a busy flag, a write-enable latch and two block-protect bits. The serial front-end passes decoded commands to the block as one-cycle request pulses:

- set the latch;
- clear the latch;
- load a new protect level;
- commit a byte write to the array.

The block drives the status byte that the front-end shifts out. It also gives the page write sequencer a level that says whether a write to a given address may go ahead.

An accepted array write or protect-level load starts a self-timed cycle of `TWC_CYCLES` clocks. During that cycle the status byte reads as all ones and every request is ignored. A new protect level takes effect only when the cycle ends, and the write-enable latch clears at that same point. A low level on the active-low write-protect pin blocks the latch from being set. It also vetoes any write whose chip-select frame saw the pin low at any time. Clearing the latch does not depend on the pin.

Protected regions are whole quarters of the array. An 8-byte page therefore lies either fully inside or fully outside a region, so the start address of a burst decides for the whole burst.

Top module: `blkprot_status`

## Requirements
- R1: After reset the status byte is 0x00: the latch is clear, the protect level is 0 and the block is idle.
- R2: The status byte layout is: bit 0 busy (1 = write cycle running), bit 1 write-enable latch, bit 2 protect bit P0, bit 3 protect bit P1. When idle, bits 7..4 read 0. While busy, all eight bits read 1.
- R3: A set-latch request sets the latch only when `wp_n` is high and the block is idle.
- R4: A clear-latch request clears the latch whatever the level of `wp_n`, when the block is idle.
- R5: Protect level {P1,P0} guards a region of the array: 00 guards nothing, 01 the top quarter, 10 the top half, 11 everything. For a 9-bit address these are none, 0x180-0x1FF, 0x100-0x1FF and 0x000-0x1FF.
- R6: `wr_permit` is high only when all of these hold: the latch is set, `wp_n` is high, `wp_n` was not low at any point since the last falling edge of `cs_n`, the block is idle, and `wr_addr` lies outside the guarded region. A `wr_req` while `wr_permit` is low changes nothing.
- R7: A protect-level load needs the same latch, pin and idle conditions, but no address test. It takes status bits 3..2 from `wrsr_data[3:2]` and ignores all other data bits.
- R8: An accepted write or load holds busy for exactly `TWC_CYCLES` clocks after the commit edge. The new protect level appears, and the latch clears, when busy falls.
- R9: Requests arriving while busy, including in its last cycle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_req | input | 1 | Set-latch request pulse |
| wrdi_req | input | 1 | Clear-latch request pulse |
| wrsr_req | input | 1 | Protect-level load request pulse |
| wrsr_data | input | 8 | Data byte for the protect-level load |
| wr_req | input | 1 | Array write commit pulse |
| wr_addr | input | AW | Start address of the page burst |
| status | output | 8 | Status byte for read-out |
| wr_permit | output | 1 | Write may proceed for `wr_addr` |
| busy | output | 1 | Timed write cycle running |

## Verification
Two collisions need care. The first is a drop of the protect pin in the same cycle as a write commit. The bench drives `wp_n` low on exactly the commit cycle and expects busy to stay low. In a separate frame the pin goes low only mid-frame and is high again at commit, and the write must still be dropped. The second collision is a set-latch request placed on the final busy clock. The bench expects the status to show the new protect level with the latch still clear, which proves that completion wins and that the request was discarded.

// File: rtl/blkprot_status.sv
module blkprot_status #(
  parameter int AW         = 9,
  parameter int TWC_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          wren_req,
  input  logic          wrdi_req,
  input  logic          wrsr_req,
  input  logic [7:0]    wrsr_data,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  output logic [7:0]    status,
  output logic          wr_permit,
  output logic          busy
);
  localparam int CW = (TWC_CYCLES > 1) ? $clog2(TWC_CYCLES) : 1;

  logic          wel, cs_q, wp_lat, bp_pend, last;
  logic [1:0]    bp, bp_next;
  logic [CW-1:0] cnt;
  logic          guarded, ok_base, start;

  always_comb begin
    case (bp)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = &wr_addr[AW-1 -: 2];
      2'b10:   guarded = wr_addr[AW-1];
      default: guarded = 1'b1;
    endcase
  end

  assign ok_base   = wel & wp_n & ~wp_lat & ~busy;
  assign wr_permit = ok_base & ~guarded;
  assign start     = (wr_req & wr_permit) | (wrsr_req & ok_base);
  assign last      = busy && (cnt == '0);
  assign status    = busy ? 8'hFF : {4'h0, bp, wel, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      wp_lat <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      wp_lat <= ((cs_q & ~cs_n) ? 1'b0 : wp_lat) | (~cs_n & ~wp_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      wel     <= 1'b0;
      bp      <= 2'b00;
      bp_next <= 2'b00;
      bp_pend <= 1'b0;
    end else if (busy) begin
      if (last) begin
        busy    <= 1'b0;
        wel     <= 1'b0;
        bp_pend <= 1'b0;
        if (bp_pend) bp <= bp_next;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= CW'(TWC_CYCLES - 1);
      bp_pend <= wrsr_req & ~wr_req;
      bp_next <= wrsr_data[3:2];
    end else if (wrdi_req) begin
      wel <= 1'b0;
    end else if (wren_req && wp_n) begin
      wel <= 1'b1;
    end
  end

  // R8
  wel_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R3
  wren_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_req && !wp_n && !wel) |=> !wel);

  // R4
  wrdi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrdi_req && !busy && !start) |=> !wel);

  // R6
  guarded_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wrsr_req && !busy && guarded) |=> !busy);

  // R8
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(bp));

  // R2
  busy_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == 8'hFF));
endmodule

// File: tb/tb_blkprot_status.sv
module tb_blkprot_status;
  localparam int AW = 9;
  localparam int TWC = 16;
  localparam time CLK_PERIOD = 10;

  localparam logic [2:0] NOP = 3'd0, WREN = 3'd1, WRDI = 3'd2, WRSR = 3'd3, WRT = 3'd4;
  localparam int NV = 36;
  // {op, wp_n, arg[8:0], expected status}
  localparam logic [20:0] VEC [NV] = '{
    {WREN, 1'b1, 9'h000, 8'h02},  // R3
    {WRDI, 1'b1, 9'h000, 8'h00},  // R4
    {WREN, 1'b0, 9'h000, 8'h00},  // R3 gated
    {WRT,  1'b1, 9'h000, 8'h00},  // R6 latch clear
    {WREN, 1'b1, 9'h000, 8'h02},
    {WRDI, 1'b0, 9'h000, 8'h00},  // R4 regardless of pin
    {WREN, 1'b1, 9'h000, 8'h02},
    {WRSR, 1'b1, 9'h004, 8'hFF},  // R2 busy all ones
    {WREN, 1'b1, 9'h000, 8'hFF},  // R9
    {NOP,  1'b1, 9'h000, 8'h04},  // R8 level 01, latch clear
    {WREN, 1'b1, 9'h000, 8'h06},
    {WRT,  1'b1, 9'h180, 8'h06},  // R5 top quarter
    {WRT,  1'b1, 9'h17F, 8'hFF},  // R5 below
    {NOP,  1'b1, 9'h000, 8'h04},
    {WREN, 1'b1, 9'h000, 8'h06},
    {WRSR, 1'b1, 9'h008, 8'hFF},
    {NOP,  1'b1, 9'h000, 8'h08},
    {WREN, 1'b1, 9'h000, 8'h0A},
    {WRT,  1'b1, 9'h100, 8'h0A},  // R5 top half
    {WRT,  1'b1, 9'h0FF, 8'hFF},
    {NOP,  1'b1, 9'h000, 8'h08},
    {WREN, 1'b1, 9'h000, 8'h0A},
    {WRSR, 1'b1, 9'h00C, 8'hFF},
    {NOP,  1'b1, 9'h000, 8'h0C},
    {WREN, 1'b1, 9'h000, 8'h0E},
    {WRT,  1'b1, 9'h000, 8'h0E},  // R5 all
    {WRT,  1'b1, 9'h1FF, 8'h0E},
    {WRSR, 1'b0, 9'h000, 8'h0E},  // R7 pin low
    {WRSR, 1'b1, 9'h0F3, 8'hFF},  // R7 bits 3..2 only
    {NOP,  1'b1, 9'h000, 8'h00},
    {WRSR, 1'b1, 9'h004, 8'h00},  // R7 latch clear
    {WREN, 1'b1, 9'h000, 8'h02},
    {WRSR, 1'b1, 9'h0F7, 8'hFF},
    {NOP,  1'b1, 9'h000, 8'h04},
    {WREN, 1'b1, 9'h000, 8'h06},
    {WRDI, 1'b1, 9'h000, 8'h04}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, wp_n = 1;
  logic wren_req = 0, wrdi_req = 0, wrsr_req = 0, wr_req = 0;
  logic [7:0] wrsr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] status;
  logic wr_permit, busy;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkprot_status #(.AW(AW), .TWC_CYCLES(TWC)) dut (
    .clk, .rst_n, .cs_n, .wp_n, .wren_req, .wrdi_req, .wrsr_req,
    .wrsr_data, .wr_req, .wr_addr, .status, .wr_permit, .busy);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic wp_frame);
    @(negedge clk); cs_n = 0; wp_n = wp_frame;
    @(negedge clk);
    @(negedge clk); cs_n = 1; wp_n = 1;
  endtask

  task automatic apply(input logic [2:0] op, input logic wpv, input logic [8:0] arg);
    if (op == NOP) begin
      repeat (TWC + 2) @(negedge clk);
      return;
    end
    frame(1'b1);
    wp_n = wpv;
    wr_addr = arg[AW-1:0];
    wrsr_data = arg[7:0];
    wren_req = (op == WREN); wrdi_req = (op == WRDI);
    wrsr_req = (op == WRSR); wr_req = (op == WRT);
    @(negedge clk);
    wren_req = 0; wrdi_req = 0; wrsr_req = 0; wr_req = 0; wp_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h00);
    check("R1 reset permit", {7'b0, wr_permit}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", status, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][20:18], VEC[i][17], VEC[i][16:8]);
      check($sformatf("R2-R9 vector %0d", i), status, VEC[i][7:0]);
    end

    // R6: permit level with latch set, level 01
    apply(WREN, 1'b1, 9'h000);
    wr_addr = 9'h17F; #1;
    check("R6 permit unguarded", {7'b0, wr_permit}, 8'h01);
    wr_addr = 9'h1C0; #1;
    check("R6 permit guarded", {7'b0, wr_permit}, 8'h00);
    wr_addr = 9'h17F; wp_n = 0; #1;
    check("R6 permit pin low", {7'b0, wr_permit}, 8'h00);
    wp_n = 1;

    // R6: pin low only mid-frame, high at commit
    frame(1'b0);
    wr_addr = 9'h010; wr_req = 1;
    @(negedge clk); wr_req = 0;
    @(negedge clk);
    check("R6 mid-frame pin drop", {7'b0, busy}, 8'h00);

    // R6: pin falls in the commit cycle
    frame(1'b1);
    wp_n = 0; wr_req = 1;
    @(negedge clk); wr_req = 0; wp_n = 1;
    @(negedge clk);
    check("R6 pin drop at commit", {7'b0, busy}, 8'h00);

    // R8 / R9: exact busy length, WREN on last busy clock ignored
    frame(1'b1);
    wrsr_data = 8'h08; wrsr_req = 1;
    @(negedge clk); wrsr_req = 0;
    repeat (TWC - 1) @(negedge clk);
    check("R8 busy on last cycle", status, 8'hFF);
    wren_req = 1;
    @(negedge clk); wren_req = 0;
    check("R9 WREN at busy end ignored", status, 8'h08);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule